// File: doc/BRIEF.md
# Image DMA Channel Buffer-Ready Register Bank

This block keeps the per-channel control state of a multi-channel image DMA engine. Each channel has four bits that software owns or shares with the engine: an enable bit, a double-buffer mode bit, and one ready flag for each of its two buffers. A busy bit per channel shows that the engine is moving data on that channel. Software reaches all of this through a plain 32-bit register port. Reads are combinational on the address. Writes take effect at the clock edge.

The engine talks to the block through two channels. On the start channel the engine offers a channel number (`st_valid`, `st_ch`). The block answers with `st_ready`, and on `st_buf` it says which buffer the transfer will use. `st_ready` depends only on the state of the channel that `st_ch` names. If `st_ready` is low the engine may hold the request or change its channel number, and nothing happens until both valid and ready are high. The done channel (`dn_valid`, `dn_ch`) has no back-pressure. When a transfer finishes, the block releases the buffer: it clears the ready flag and moves to the next buffer.

Writes to the ready registers normally set flags. A key value placed in the control word turns those same writes into clears, so software can take back buffers it has already handed over.

Top module: `dma_rdy_bank`

## Requirements
- R1: After reset every enable, mode, ready and busy bit is 0, the control word reads 0 and `st_ready` is 0.
- R2: The address is `{kind[2:0], word}`. Kind 0 is enable, 1 is double-buffer mode, 2 is buffer-0 ready, 3 is buffer-1 ready, 4 is busy (read-only) and 5 is control (word 0). Channel n sits at bit n%32 of word n/32.
- R3: Enable and double-buffer mode words are plain read/write and read back exactly what was written.
- R4: In set mode, a 1 written to a ready-register bit sets that flag, and a 0 bit leaves it unchanged.
- R5: Writing the control word stores bits [31:28], and those bits read back there. While they equal 4'hF, a 1 written to a ready bit clears that flag. Any other value, such as 0, restores set mode.
- R6: `st_ready` is 1 only when the addressed channel is enabled, its current buffer is ready and it is not busy. `st_buf` names that buffer (0 or 1). A handshake makes the channel busy from the next cycle.
- R7: A done on a busy channel clears its busy bit and the ready flag of the buffer it used. A done on a channel that is not busy changes nothing.
- R8: In double-buffer mode a channel uses buffer 0, then 1, then 0 again. In single-buffer mode it always uses buffer 0, whatever buffer 1's flag holds.
- R9: If a software set and an engine clear hit the same ready flag in the same cycle, the flag ends up set.
- R10: The busy words read each channel's busy bit.
- R11: Writes to the busy words have no effect, and kinds 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address {kind, word} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| st_valid | input | 1 | Engine offers a transfer start |
| st_ch | input | 6 | Channel of the start offer |
| st_ready | output | 1 | Start accepted for st_ch |
| st_buf | output | 1 | Buffer the start uses |
| dn_valid | input | 1 | Engine finished a transfer |
| dn_ch | input | 6 | Channel of the finished transfer |

## Verification
The bench builds the block with its defaults: 64 channels in two 32-bit words per kind, so the address is four bits wide. With those values, channels 31, 32 and 63 test the edges of each word. Kinds 6 and 7 give real unmapped addresses. Single-buffer and double-buffer sequences, a clear-mode revocation, and a software set that lands in the same cycle as an engine clear are all driven on real channel numbers.

// File: rtl/rdy_bank_pkg.sv
package rdy_bank_pkg;
  typedef enum logic [2:0] {
    K_EN   = 3'd0,
    K_DB   = 3'd1,
    K_RDY0 = 3'd2,
    K_RDY1 = 3'd3,
    K_BUSY = 3'd4,
    K_CTRL = 3'd5
  } kind_e;

  localparam logic [3:0] CLR_KEY = 4'hF;
endpackage

// File: rtl/rdy_bus_dec.sv
module rdy_bus_dec import rdy_bank_pkg::*; #(
  parameter int NWORDS = 2,
  parameter int ADDR_W = 4,
  parameter int WSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        wtop,
  output logic [NWORDS-1:0] en_we,
  output logic [NWORDS-1:0] db_we,
  output logic [NWORDS-1:0] r0_we,
  output logic [NWORDS-1:0] r1_we,
  output logic [3:0]        ctrl_q,
  output logic              clr_mode
);
  logic [2:0]        kind;
  logic [WSEL_W-1:0] widx;

  assign kind = reg_addr[ADDR_W-1 -: 3];
  assign widx = reg_addr[WSEL_W-1:0];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    assign hit      = reg_we && (widx == WSEL_W'(w));
    assign en_we[w] = hit && (kind == K_EN);
    assign db_we[w] = hit && (kind == K_DB);
    assign r0_we[w] = hit && (kind == K_RDY0);
    assign r1_we[w] = hit && (kind == K_RDY1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_we && kind == K_CTRL && widx == '0) ctrl_q <= wtop;
  end

  assign clr_mode = (ctrl_q == CLR_KEY);
endmodule

// File: rtl/rdy_chan_slice.sv
module rdy_chan_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic en_we,
  input  logic db_we,
  input  logic wbit,
  input  logic r0_sw,
  input  logic r1_sw,
  input  logic clr_mode,
  input  logic start_fire,
  input  logic done_fire,
  output logic en_q,
  output logic db_q,
  output logic r0_q,
  output logic r1_q,
  output logic busy_q,
  output logic can_start,
  output logic cur_buf
);
  logic cur_q, fin;
  logic r0_n, r1_n, cur_n, busy_n;

  assign cur_buf   = db_q & cur_q;
  assign can_start = en_q & ~busy_q & (cur_buf ? r1_q : r0_q);
  assign fin       = done_fire & busy_q;

  always_comb begin
    r0_n   = r0_q;
    r1_n   = r1_q;
    cur_n  = cur_q;
    busy_n = busy_q;
    if (start_fire) busy_n = 1'b1;
    if (fin) begin
      busy_n = 1'b0;
      if (cur_buf) r1_n = 1'b0;
      else         r0_n = 1'b0;
      cur_n = db_q ? ~cur_buf : 1'b0;
    end
    // software writes are applied last so they win over the engine clear
    if (r0_sw) r0_n = ~clr_mode;
    if (r1_sw) r1_n = ~clr_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      db_q   <= 1'b0;
      r0_q   <= 1'b0;
      r1_q   <= 1'b0;
      busy_q <= 1'b0;
      cur_q  <= 1'b0;
    end else begin
      if (en_we) en_q <= wbit;
      if (db_we) db_q <= wbit;
      r0_q   <= r0_n;
      r1_q   <= r1_n;
      busy_q <= busy_n;
      cur_q  <= cur_n;
    end
  end
endmodule

// File: rtl/rdy_rd_mux.sv
module rdy_rd_mux import rdy_bank_pkg::*; #(
  parameter int NUM_CH = 64,
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  parameter int ADDR_W = 4,
  parameter int WSEL_W = 1
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_CH-1:0] en_v,
  input  logic [NUM_CH-1:0] db_v,
  input  logic [NUM_CH-1:0] r0_v,
  input  logic [NUM_CH-1:0] r1_v,
  input  logic [NUM_CH-1:0] busy_v,
  input  logic [3:0]        ctrl_q,
  output logic [WORD_W-1:0] reg_rdata
);
  logic [2:0]        kind;
  logic [WSEL_W-1:0] widx;
  int unsigned       base;

  assign kind = reg_addr[ADDR_W-1 -: 3];
  assign widx = reg_addr[WSEL_W-1:0];

  always_comb begin
    reg_rdata = '0;
    base      = 32'(widx) * WORD_W;
    if (32'(widx) < NWORDS) begin
      case (kind)
        K_EN:   reg_rdata = en_v[base +: WORD_W];
        K_DB:   reg_rdata = db_v[base +: WORD_W];
        K_RDY0: reg_rdata = r0_v[base +: WORD_W];
        K_RDY1: reg_rdata = r1_v[base +: WORD_W];
        K_BUSY: reg_rdata = busy_v[base +: WORD_W];
        K_CTRL: if (widx == '0) reg_rdata = {ctrl_q, {(WORD_W-4){1'b0}}};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_rdy_bank.sv
module dma_rdy_bank #(
  parameter int NUM_CH = 64,
  parameter int WORD_W = 32,
  localparam int NWORDS = NUM_CH / WORD_W,
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int ADDR_W = 3 + WSEL_W,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              st_valid,
  input  logic [CH_W-1:0]   st_ch,
  output logic              st_ready,
  output logic              st_buf,
  input  logic              dn_valid,
  input  logic [CH_W-1:0]   dn_ch
);
  logic [NWORDS-1:0] en_we, db_we, r0_we, r1_we;
  logic [3:0]        ctrl_q;
  logic              clr_mode;
  logic [NUM_CH-1:0] en_q, db_q, r0_q, r1_q, busy_q, can_start, cur_buf;

  rdy_bus_dec #(.NWORDS(NWORDS), .ADDR_W(ADDR_W), .WSEL_W(WSEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wtop(reg_wdata[WORD_W-1 -: 4]),
    .en_we(en_we), .db_we(db_we), .r0_we(r0_we), .r1_we(r1_we),
    .ctrl_q(ctrl_q), .clr_mode(clr_mode)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int W = i / WORD_W;
    localparam int B = i % WORD_W;
    rdy_chan_slice u_slice (
      .clk(clk), .rst_n(rst_n),
      .en_we(en_we[W]), .db_we(db_we[W]), .wbit(reg_wdata[B]),
      .r0_sw(r0_we[W] & reg_wdata[B]), .r1_sw(r1_we[W] & reg_wdata[B]),
      .clr_mode(clr_mode),
      .start_fire(st_valid & can_start[i] & (st_ch == CH_W'(i))),
      .done_fire(dn_valid & (dn_ch == CH_W'(i))),
      .en_q(en_q[i]), .db_q(db_q[i]), .r0_q(r0_q[i]), .r1_q(r1_q[i]),
      .busy_q(busy_q[i]), .can_start(can_start[i]), .cur_buf(cur_buf[i])
    );
  end

  assign st_ready = can_start[st_ch];
  assign st_buf   = cur_buf[st_ch];

  rdy_rd_mux #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .NWORDS(NWORDS),
               .ADDR_W(ADDR_W), .WSEL_W(WSEL_W)) u_rd (
    .reg_addr(reg_addr), .en_v(en_q), .db_v(db_q), .r0_v(r0_q), .r1_v(r1_q),
    .busy_v(busy_q), .ctrl_q(ctrl_q), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/rdy_bank_chk.sv
module rdy_bank_chk #(
  parameter int NUM_CH = 64,
  parameter int CH_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic [CH_W-1:0]   st_ch,
  input logic              st_buf,
  input logic              dn_valid,
  input logic [CH_W-1:0]   dn_ch,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] busy_q,
  input logic [NUM_CH-1:0] r0_q,
  input logic [NUM_CH-1:0] r1_q
);
  // R6: a granted start makes that channel busy
  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> busy_q[$past(st_ch)]);

  // R6: a grant only goes to an enabled, idle channel whose chosen buffer is ready
  a_r6_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |-> en_q[st_ch] && !busy_q[st_ch] &&
                             (st_buf ? r1_q[st_ch] : r0_q[st_ch]));

  // R6: at most one channel becomes busy per cycle
  a_r6_one_new_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_q & ~$past(busy_q)) <= 1);

  // R7: a done on a busy channel ends its busy state
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && busy_q[dn_ch] |=> !busy_q[$past(dn_ch)]);

  // R7: busy only falls after a done
  a_r7_drop_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~busy_q & $past(busy_q))) |-> $past(dn_valid));
endmodule

bind dma_rdy_bank rdy_bank_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_ch(st_ch), .st_buf(st_buf), .dn_valid(dn_valid), .dn_ch(dn_ch),
  .en_q(en_q), .busy_q(busy_q), .r0_q(r0_q), .r1_q(r1_q)
);

// File: tb/tb_dma_rdy_bank.sv
`timescale 1ns/1ps
module tb_dma_rdy_bank;
  localparam logic [3:0] A_EN0 = 4'd0, A_EN1 = 4'd1, A_DB0 = 4'd2, A_DB1 = 4'd3,
                         A_R00 = 4'd4, A_R01 = 4'd5, A_R10 = 4'd6, A_R11 = 4'd7,
                         A_BS0 = 4'd8, A_BS1 = 4'd9, A_CTL = 4'd10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic st_valid = 0, st_ready, st_buf, dn_valid = 0;
  logic [5:0] st_ch = 0, dn_ch = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_rdy_bank dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp, logic [31:0] m = '1);
    reg_addr = a; #1;
    chk(tag, reg_rdata & m, exp & m);
  endtask

  task automatic start(string tag, logic [5:0] ch, logic exp_rdy, logic exp_buf);
    @(negedge clk); st_valid = 1; st_ch = ch; #1;
    chk({tag, " ready"}, 32'(st_ready), 32'(exp_rdy));
    if (exp_rdy) chk({tag, " buf"}, 32'(st_buf), 32'(exp_buf));
    @(negedge clk); st_valid = 0;
  endtask

  task automatic done(logic [5:0] ch);
    @(negedge clk); dn_valid = 1; dn_ch = ch;
    @(negedge clk); dn_valid = 0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) rd("R1 reset read", 4'(a), 0);
    st_ch = 0; #1; chk("R1 st_ready after reset", 32'(st_ready), 0);
  endtask

  task automatic t_rw;
    wr(A_EN0, 32'h8000_0001); wr(A_EN1, 32'h4000_0002); wr(A_DB1, 32'h0000_0002);
    rd("R2 R3 enable word0", A_EN0, 32'h8000_0001);
    rd("R2 R3 enable word1", A_EN1, 32'h4000_0002);
    rd("R3 mode word1", A_DB1, 32'h0000_0002);
    rd("R3 mode word0 untouched", A_DB0, 0);
    wr(A_EN0, 0); wr(A_EN1, 0); wr(A_DB1, 0);
    rd("R3 enable cleared", A_EN1, 0);
  endtask

  task automatic t_setmode;
    wr(A_R01, 32'h5); rd("R4 set bits", A_R01, 32'h5);
    wr(A_R01, 32'h2); rd("R4 accumulate", A_R01, 32'h7);
    wr(A_R01, 32'h0); rd("R4 zero no effect", A_R01, 32'h7);
    wr(A_BS1, 32'hFFFF_FFFF); rd("R11 busy write ignored", A_BS1, 0);
    rd("R11 kind6 reads 0", 4'd12, 0); rd("R11 kind7 reads 0", 4'd15, 0);
  endtask

  task automatic t_clrmode;
    wr(A_CTL, 32'hF000_0000); rd("R5 ctrl readback", A_CTL, 32'hF000_0000);
    wr(A_R01, 32'h4); rd("R5 clear mode revokes", A_R01, 32'h3);
    wr(A_CTL, 32'h7000_0000);
    wr(A_R01, 32'h8); rd("R5 non-key sets", A_R01, 32'hB);
    wr(A_CTL, 32'h0); rd("R5 ctrl zero", A_CTL, 0);
    wr(A_R01, 32'h4); rd("R5 set restored", A_R01, 32'hF);
    wr(A_CTL, 32'hF000_0000); wr(A_R01, 32'hF); wr(A_CTL, 0);
    rd("R5 cleaned", A_R01, 0);
  endtask

  task automatic t_single;
    wr(A_EN1, 32'h1);
    start("R6 not ready without flag", 6'd32, 0, 0);
    wr(A_R01, 32'h1); wr(A_R11, 32'h1);
    start("R6 single start", 6'd32, 1, 0);
    rd("R10 busy shown", A_BS1, 32'h1);
    start("R6 busy blocks", 6'd32, 0, 0);
    done(32);
    rd("R7 busy cleared", A_BS1, 0);
    rd("R7 buf0 released", A_R01, 0);
    rd("R7 buf1 kept", A_R11, 32'h1);
    start("R8 single ignores buf1", 6'd32, 0, 0);
    wr(A_R01, 32'h1);
    start("R8 single again buf0", 6'd32, 1, 0);
    done(32);
  endtask

  task automatic t_double;
    wr(A_EN0, 32'h8000_0000); wr(A_DB0, 32'h8000_0000);
    wr(A_R00, 32'h8000_0000); wr(A_R10, 32'h8000_0000);
    start("R8 double first buf0", 6'd31, 1, 0);
    done(31);
    rd("R8 buf0 freed", A_R00, 0);
    rd("R8 buf1 still", A_R10, 32'h8000_0000);
    start("R8 double second buf1", 6'd31, 1, 1);
    done(31);
    rd("R8 buf1 freed", A_R10, 0);
    start("R8 wait buf0", 6'd31, 0, 0);
    wr(A_R00, 32'h8000_0000);
    start("R8 back to buf0", 6'd31, 1, 0);
    done(31);
  endtask

  task automatic t_race;
    wr(A_EN1, 32'h8000_0001); wr(A_R01, 32'h8000_0000);
    start("R9 start ch63", 6'd63, 1, 0);
    @(negedge clk);
    dn_valid = 1; dn_ch = 63; reg_we = 1; reg_addr = A_R01; reg_wdata = 32'h8000_0000;
    @(negedge clk); dn_valid = 0; reg_we = 0;
    rd("R9 busy ended", A_BS1, 0, 32'h8000_0000);
    rd("R9 software set wins", A_R01, 32'h8000_0000, 32'h8000_0000);
    wr(A_R00, 32'h20);
    done(5);
    rd("R7 done on idle ignored", A_R00, 32'h20, 32'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_rw; t_setmode; t_clrmode; t_single; t_double; t_race;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule